// File: doc/BRIEF.md
# Dual Timer/Counter Pair

This block holds two independent 8-bit-pair timer/counters for a small microcontroller core. Each unit has a low and a high count byte and a four-bit configuration (gate enable, count-source select, two mode bits). A unit advances either on every machine-cycle strobe or on each falling edge of its external count pin. It may also be started by its external gate pin instead of its run bit. Each unit runs in one of four modes: a 13-bit count with a 5-bit prescaler, a 16-bit cascade, an 8-bit count with automatic reload, and a split mode. In split mode timer 0 becomes two 8-bit counters, and its high byte takes over timer 1's run bit and overflow flag.

Software reaches all state through a small register port, with a write strobe and a combinational read mux. The core sees the two overflow flags as level outputs. The serial port's baud logic receives a one-cycle pulse for every timer-1 overflow. It receives the same pulse for every overflow of timer 0's high byte in split mode.

Top module: `tc_pair`

## Requirements
- R1: After reset every count byte, both configurations, both run bits and both flags read zero, and `ovf0_o`, `ovf1_o` and `baud_o` are low.
- R2: A unit runs when its run bit is set, or when its gate bit is set and its synchronized gate pin is high. In timer mode a running unit advances once per clock in which `tick_i` is high. A unit that is not running does not change.
- R3: With the count-source bit set, a running unit advances once per falling edge of its count pin and ignores `tick_i`. The pin is first passed through two flops, and an edge is a high sample followed by a low sample.
- R4: In mode 0, bits [4:0] of the low byte form a prescaler. When they are all ones, an advance clears the whole low byte and increments the high byte. Otherwise the upper three low-byte bits hold. A high byte wrapping to zero sets the unit's flag.
- R5: In mode 1 the high and low bytes form one 16-bit counter, and a wrap from 0xFFFF to zero sets the flag.
- R6: In mode 2 only the low byte counts. An advance from 0xFF loads the low byte from the high byte and sets the flag.
- R7: In mode 3, timer 0's low byte is an 8-bit counter under timer 0's run/gate that sets flag 0. Timer 0's high byte counts machine cycles under timer 1's run/gate and sets flag 1 when it wraps.
- R8: Timer 1 in mode 3 holds both of its bytes whatever its run bit, gate or ticks.
- R9: `baud_o` is high for exactly one cycle, the cycle after each timer-1 overflow or split-mode timer-0 high-byte overflow.
- R10: A register write to a count byte in the same cycle as an advance of that byte stores the written value.
- R11: Flags are sticky: they are set by overflow, and written directly by a control write, with an overflow in the same cycle winning over a cleared bit.
- R12: Register addresses are 0 TL0, 1 TH0, 2 TL1, 3 TH1, 4 configuration, 5 control. The configuration byte is timer 0 in bits [3:0] and timer 1 in bits [7:4], each nibble being {gate, count-source, mode[1:0]}. The control byte is bit 0 run 0, bit 1 run 1, bit 2 flag 0, bit 3 flag 1, and its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Machine-cycle strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data for `addr_i` |
| cnt_pin_i | input | 2 | External count pins, bit g for timer g |
| gate_pin_i | input | 2 | External gate pins, bit g for timer g |
| ovf0_o | output | 1 | Timer 0 overflow flag |
| ovf1_o | output | 1 | Timer 1 overflow flag |
| baud_o | output | 1 | Overflow pulse for the serial baud logic |

## Verification
The assertions assume that the pins are asynchronous levels that only matter after the flop chain. They also assume that a count byte written in the same cycle as an overflow is excluded from the reload and hold checks, so the properties carry the write strobes in their antecedents. The stimulus holds each count-pin level for at least three cycles, so that every edge crosses the synchronizer. It also issues register writes only in cycles where `tick_i` is low, except in the one case that exercises write priority on purpose. The mode sweep covers both timers in each non-split mode from starts that lie just below the prescaler carry, the 16-bit wrap and the reload point.

// File: rtl/tc_pkg.sv
package tc_pkg;
   typedef enum logic [1:0] {
      TC_M13   = 2'd0,
      TC_M16   = 2'd1,
      TC_M8R   = 2'd2,
      TC_SPLIT = 2'd3
   } tc_mode_e;

   typedef struct packed {
      logic     gate;
      logic     cnt_sel;
      tc_mode_e mode;
   } tc_cfg_t;

   localparam logic [2:0] A_TL0  = 3'd0;
   localparam logic [2:0] A_TH0  = 3'd1;
   localparam logic [2:0] A_TL1  = 3'd2;
   localparam logic [2:0] A_TH1  = 3'd3;
   localparam logic [2:0] A_CFG  = 3'd4;
   localparam logic [2:0] A_CTRL = 3'd5;
endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] level_o,
   output logic [N-1:0] fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tc_sync needs at least two synchronizer stages");
   end

   for (genvar g = 0; g < N; g++) begin : g_pin
      logic [STAGES:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-1:0], pin_i[g]};
      end
      assign level_o[g] = sh[STAGES-1];
      assign fall_o[g]  = sh[STAGES] & ~sh[STAGES-1];

      assert_one_cycle_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
         fall_o[g] |=> !fall_o[g])
         else $error("edge strobe longer than one cycle");
   end
endmodule

// File: rtl/tc_unit.sv
module tc_unit
   import tc_pkg::*;
#(
   parameter int W         = 8,
   parameter int PRE_W     = 5,
   parameter bit HAS_SPLIT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  tc_mode_e     mode_i,
   input  logic         inc_i,
   input  logic         hi_inc_i,
   input  logic         wr_lo_i,
   input  logic         wr_hi_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] lo_o,
   output logic [W-1:0] hi_o,
   output logic         ovf_o,
   output logic         hi_ovf_o
);
   localparam logic [W-1:0]     ONE   = W'(1);
   localparam logic [2*W-1:0]   ONE2  = (2*W)'(1);
   localparam logic [PRE_W-1:0] ONE_P = PRE_W'(1);

   logic [W-1:0] lo_q, hi_q, lo_n, hi_n;
   logic [W-1:0] sp_lo, sp_hi;
   logic         sp_ovf, sp_hovf;

   if (HAS_SPLIT) begin : g_split
      always_comb begin
         sp_lo   = inc_i    ? lo_q + ONE : lo_q;
         sp_ovf  = inc_i    & (&lo_q);
         sp_hi   = hi_inc_i ? hi_q + ONE : hi_q;
         sp_hovf = hi_inc_i & (&hi_q);
      end
   end else begin : g_hold
      logic unused_hi_inc;
      assign unused_hi_inc = hi_inc_i;
      assign sp_lo   = lo_q;
      assign sp_hi   = hi_q;
      assign sp_ovf  = 1'b0;
      assign sp_hovf = 1'b0;
   end

   always_comb begin
      lo_n     = lo_q;
      hi_n     = hi_q;
      ovf_o    = 1'b0;
      hi_ovf_o = 1'b0;
      unique case (mode_i)
         TC_M13: if (inc_i) begin
            if (&lo_q[PRE_W-1:0]) begin
               lo_n  = '0;
               hi_n  = hi_q + ONE;
               ovf_o = &hi_q;
            end else begin
               lo_n = {lo_q[W-1:PRE_W], lo_q[PRE_W-1:0] + ONE_P};
            end
         end
         TC_M16: if (inc_i) begin
            {hi_n, lo_n} = {hi_q, lo_q} + ONE2;
            ovf_o        = &{hi_q, lo_q};
         end
         TC_M8R: if (inc_i) begin
            if (&lo_q) begin
               lo_n  = hi_q;
               ovf_o = 1'b1;
            end else begin
               lo_n = lo_q + ONE;
            end
         end
         default: begin
            lo_n     = sp_lo;
            hi_n     = sp_hi;
            ovf_o    = sp_ovf;
            hi_ovf_o = sp_hovf;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= wr_lo_i ? wdata_i : lo_n;
         hi_q <= wr_hi_i ? wdata_i : hi_n;
      end
   end

   assign lo_o = lo_q;
   assign hi_o = hi_q;

   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == TC_M8R && ovf_o && !wr_lo_i) |=> (lo_q == $past(hi_q)))
      else $error("reload did not copy high byte");

   assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !hi_inc_i && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)))
      else $error("count moved without a stimulus");
endmodule

// File: rtl/tc_pair.sv
module tc_pair
   import tc_pkg::*;
#(
   parameter int W      = 8,
   parameter int PRE_W  = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         wr_en_i,
   input  logic [2:0]   addr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] rdata_o,
   input  logic [1:0]   cnt_pin_i,
   input  logic [1:0]   gate_pin_i,
   output logic         ovf0_o,
   output logic         ovf1_o,
   output logic         baud_o
);
   localparam int NPIN = 4;

   if (W < 8) begin : g_bad_w
      $error("tc_pair needs a byte-wide register port");
   end
   if (PRE_W >= W) begin : g_bad_pre
      $error("prescaler must be narrower than a count byte");
   end

   tc_cfg_t     cfg_q [2];
   logic [1:0]  run_q, flag_q, run_eff, inc, set;
   logic [1:0]  wr_lo, wr_hi, u_ovf, u_hovf, hi_inc;
   logic [W-1:0] lo [2];
   logic [W-1:0] hi [2];
   logic [NPIN-1:0] pin_lvl, pin_fall;
   logic        ctrl_wr, cfg_wr, baud_q;

   tc_sync #(.N(NPIN), .STAGES(STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   ({gate_pin_i, cnt_pin_i}),
      .level_o (pin_lvl),
      .fall_o  (pin_fall)
   );

   assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);
   assign cfg_wr  = wr_en_i && (addr_i == A_CFG);

   for (genvar g = 0; g < 2; g++) begin : g_tmr
      localparam logic [2:0] ALO = (g == 0) ? A_TL0 : A_TL1;
      localparam logic [2:0] AHI = (g == 0) ? A_TH0 : A_TH1;

      assign run_eff[g] = run_q[g] | (cfg_q[g].gate & pin_lvl[2+g]);
      assign inc[g]     = run_eff[g] & (cfg_q[g].cnt_sel ? pin_fall[g] : tick_i);
      assign wr_lo[g]   = wr_en_i && (addr_i == ALO);
      assign wr_hi[g]   = wr_en_i && (addr_i == AHI);

      tc_unit #(.W(W), .PRE_W(PRE_W), .HAS_SPLIT(g == 0)) unit_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .mode_i   (cfg_q[g].mode),
         .inc_i    (inc[g]),
         .hi_inc_i (hi_inc[g]),
         .wr_lo_i  (wr_lo[g]),
         .wr_hi_i  (wr_hi[g]),
         .wdata_i  (wdata_i),
         .lo_o     (lo[g]),
         .hi_o     (hi[g]),
         .ovf_o    (u_ovf[g]),
         .hi_ovf_o (u_hovf[g])
      );
   end

   assign hi_inc[0] = run_eff[1] & tick_i;
   assign hi_inc[1] = 1'b0;
   assign set[0]    = u_ovf[0];
   assign set[1]    = u_ovf[1] | u_hovf[0] | u_hovf[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q[0] <= '0;
         cfg_q[1] <= '0;
         run_q    <= '0;
         flag_q   <= '0;
         baud_q   <= 1'b0;
      end else begin
         if (cfg_wr) begin
            cfg_q[0] <= tc_cfg_t'(wdata_i[3:0]);
            cfg_q[1] <= tc_cfg_t'(wdata_i[7:4]);
         end
         if (ctrl_wr) begin
            run_q  <= wdata_i[1:0];
            flag_q <= wdata_i[3:2] | set;
         end else begin
            flag_q <= flag_q | set;
         end
         baud_q <= set[1];
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         A_TL0:   rdata_o = lo[0];
         A_TH0:   rdata_o = hi[0];
         A_TL1:   rdata_o = lo[1];
         A_TH1:   rdata_o = hi[1];
         A_CFG:   rdata_o[7:0] = {cfg_q[1], cfg_q[0]};
         A_CTRL:  rdata_o[3:0] = {flag_q, run_q};
         default: rdata_o = '0;
      endcase
   end

   assign ovf0_o = flag_q[0];
   assign ovf1_o = flag_q[1];
   assign baud_o = baud_q;

   assert_baud_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      baud_o |-> ovf1_o)
      else $error("baud pulse without timer 1 flag");

   assert_baud_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_o && !$past(set[1])) |-> 1'b0)
      else $error("baud pulse without a preceding overflow");

   assert_t1_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[1].mode == TC_SPLIT && !wr_lo[1] && !wr_hi[1]) |=> ($stable(lo[1]) && $stable(hi[1])))
      else $error("timer 1 moved in mode 3");

   assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[0] && !ctrl_wr) |=> flag_q[0])
      else $error("flag 0 dropped without a control write");
endmodule

// File: tb/tc_pair_tb.sv
`timescale 1ns/1ps
module tc_pair_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic [1:0] cnt_pin = 2'b11;
   logic [1:0] gate_pin = 2'b00;
   logic       ovf0, ovf1, baud;
   int         checks = 0;
   int         errors = 0;
   int         baud_cnt = 0;

   always #10 clk = ~clk;

   tc_pair dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .cnt_pin_i(cnt_pin), .gate_pin_i(gate_pin),
      .ovf0_o(ovf0), .ovf1_o(ovf1), .baud_o(baud)
   );

   always @(negedge clk) if (rst_n && baud) baud_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   // one advance of a count pair: returns {ovf, th, tl}
   function automatic logic [16:0] step(input int m, input logic [7:0] tl, input logic [7:0] th);
      logic [15:0] v;
      if (m == 0) begin
         if (tl[4:0] == 5'h1F) return {th == 8'hFF, th + 8'd1, 8'h00};
         return {1'b0, th, tl[7:5], tl[4:0] + 5'd1};
      end else if (m == 1) begin
         v = {th, tl} + 16'd1;
         return {v == 16'd0, v};
      end
      if (tl == 8'hFF) return {1'b1, th, th};
      return {1'b0, th, tl + 8'd1};
   endfunction

   task automatic run_case(input int tmr, input int m, input logic [7:0] tl,
                           input logic [7:0] th, input int n);
      logic [7:0] etl, eth, v;
      logic       eovf;
      logic [16:0] r;
      string req;
      req = (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
      wr(3'd5, 8'h00);
      wr(3'd4, tmr ? 8'(m << 4) : 8'(m));
      wr(tmr ? 3'd2 : 3'd0, tl);
      wr(tmr ? 3'd3 : 3'd1, th);
      wr(3'd5, tmr ? 8'h02 : 8'h01);
      ticks(n);
      etl = tl; eth = th; eovf = 1'b0;
      for (int i = 0; i < n; i++) begin
         r = step(m, etl, eth);
         eovf |= r[16]; eth = r[15:8]; etl = r[7:0];
      end
      rd(tmr ? 3'd2 : 3'd0, v); chk({req, " low byte"}, v, etl);
      rd(tmr ? 3'd3 : 3'd1, v); chk({req, " high byte"}, v, eth);
      rd(3'd5, v);              chk({req, " flag"}, v[2+tmr], eovf);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      int b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v); chk("R1 register after reset", v, 0);
      end
      chk("R1 outputs after reset", {ovf0, ovf1, baud}, 0);

      // R12 map and read-back
      wr(3'd4, 8'h5A); rd(3'd4, v); chk("R12 configuration readback", v, 8'h5A);
      wr(3'd5, 8'hF0); rd(3'd5, v); chk("R12 control upper bits", v, 8'h00);
      wr(3'd4, 8'h00);

      // R11 flags written directly
      wr(3'd5, 8'h0C); rd(3'd5, v); chk("R11 flags written", v, 8'h0C);
      chk("R11 flag outputs", {ovf1, ovf0}, 2'b11);
      wr(3'd5, 8'h00); chk("R11 flags cleared", {ovf1, ovf0}, 2'b00);

      // R4 R5 R6 sweep, both timers
      for (int t = 0; t < 2; t++)
         for (int m = 0; m < 3; m++) begin
            run_case(t, m, 8'hFD, 8'hFF, 3);
            run_case(t, m, 8'hFD, 8'hFF, 40);
            run_case(t, m, 8'hE0, 8'h12, 3);
            run_case(t, m, 8'hE0, 8'h12, 40);
            run_case(t, m, 8'hFE, 8'hC0, 3);
            run_case(t, m, 8'hFE, 8'hC0, 40);
         end

      // R2 not running: no count; gate pin start
      wr(3'd5, 8'h00); wr(3'd4, 8'h08); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
      ticks(5); rd(3'd0, v); chk("R2 gated with pin low", v, 0);
      gate_pin[0] = 1'b1; repeat (4) @(negedge clk);
      ticks(6); rd(3'd0, v); chk("R2 gate pin starts timer", v, 6);
      gate_pin[0] = 1'b0; repeat (4) @(negedge clk);
      wr(3'd4, 8'h00); gate_pin[0] = 1'b1; repeat (4) @(negedge clk);
      ticks(4); rd(3'd0, v); chk("R2 pin ignored with gate bit clear", v, 6);
      gate_pin[0] = 1'b0;

      // R3 counter mode
      wr(3'd4, 8'h04); wr(3'd0, 8'h00); wr(3'd5, 8'h01);
      for (int p = 0; p < 5; p++) begin
         cnt_pin[0] = 1'b0; repeat (3) @(negedge clk);
         cnt_pin[0] = 1'b1; repeat (3) @(negedge clk);
      end
      repeat (3) @(negedge clk);
      rd(3'd0, v); chk("R3 falling edges counted", v, 5);
      ticks(10); rd(3'd0, v); chk("R3 ticks ignored in counter mode", v, 5);

      // R10 write priority
      wr(3'd4, 8'h01); wr(3'd0, 8'h10); wr(3'd5, 8'h01);
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 8'h55;
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
      #1 chk("R10 write beats advance", rdata, 8'h55);

      // R7 split mode
      wr(3'd5, 8'h00); wr(3'd4, 8'h03);
      wr(3'd0, 8'hFE); wr(3'd1, 8'hFD); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      b0 = baud_cnt;
      wr(3'd5, 8'h03);
      ticks(4); repeat (2) @(negedge clk);
      rd(3'd0, v); chk("R7 split low byte", v, 8'h02);
      rd(3'd1, v); chk("R7 split high byte", v, 8'h01);
      rd(3'd5, v); chk("R7 split flags", v[3:2], 2'b11);
      chk("R9 split high overflow pulse", baud_cnt - b0, 1);
      wr(3'd5, 8'h01); ticks(3);
      rd(3'd1, v); chk("R7 high byte follows run 1", v, 8'h01);
      rd(3'd0, v); chk("R7 low byte follows run 0", v, 8'h05);

      // R8 timer 1 in mode 3 holds
      wr(3'd5, 8'h00); wr(3'd4, 8'h30); wr(3'd2, 8'h77); wr(3'd3, 8'h88);
      wr(3'd5, 8'h02); ticks(10);
      rd(3'd2, v); chk("R8 timer 1 low held", v, 8'h77);
      rd(3'd3, v); chk("R8 timer 1 high held", v, 8'h88);
      chk("R8 no flag", ovf1, 0);

      // R9 baud pulses from timer 1 reload mode
      wr(3'd5, 8'h00); wr(3'd4, 8'h20); wr(3'd2, 8'hFC); wr(3'd3, 8'hFC);
      b0 = baud_cnt;
      wr(3'd5, 8'h02); ticks(12); repeat (3) @(negedge clk);
      chk("R9 timer 1 overflow pulses", baud_cnt - b0, 3);
      chk("R9 pulse ended", baud, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule